// File: doc/BRIEF.md
# Physical Register Reference Counter

This block keeps a live-mapping count for every integer physical register of a renamer that eliminates register moves. An eliminated move takes its source register as its destination, so one physical register may sit behind several architectural mappings at once. It may go back to the pool only when the last of those mappings has gone.

Each rename lane reports a new mapping with a valid bit and a register index. The renamer raises that valid bit only when it really writes the speculative integer table. Each commit lane reports a released mapping. During normal retirement the lane releases the entry's previous destination. During a recovery walk it releases the entry's new destination. A mode input picks which of the two indexes each lane uses.

All increments and decrements that land on one register in a cycle are added together before its saturating count is written. When a released register's count becomes zero, the lane that released it raises a free pulse with the index on the following cycle. That pulse is wired straight to the free list's return port.

Top module: `preg_refcount`

## Requirements
- R1: After reset, registers with index below INIT_MAPPED hold a count of one, all others hold zero, and every free output is low.
- R2: When walk_mode is 1, a commit lane releases its rel_new_idx. When walk_mode is 0, it releases its rel_old_idx. The unselected index has no effect.
- R3: A free appears on free_vld/free_idx of the releasing lane exactly one cycle after the release, and only when the register's count becomes zero.
- R4: A register whose count stays above zero after a release (a move-shared register) produces no free.
- R5: All allocations and releases aimed at one register in one cycle are summed into a single update. An allocation and a release of the same register in one cycle leave its count unchanged.
- R6: If several lanes release the same register in a cycle and it reaches zero, only the lowest-numbered of those lanes reports the free. Releases of different registers in the same cycle free independently.
- R7: Counts saturate at 2^CNT_W-1, so further allocations beyond that value are not counted. Counts never go below zero.
- R8: An allocate or release lane with its valid low changes no count, whatever its index inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_vld | input | AL | Per rename lane: a new mapping was written |
| alloc_idx | input | AL x IDX_W | Per rename lane: physical register of the new mapping |
| walk_mode | input | 1 | 1 = recovery walk, 0 = normal retirement |
| rel_vld | input | CL | Per commit lane: a mapping with an integer destination is released |
| rel_new_idx | input | CL x IDX_W | Per commit lane: the entry's new destination register |
| rel_old_idx | input | CL x IDX_W | Per commit lane: the entry's previous destination register |
| free_vld | output | CL | Per commit lane: register returns to the free list |
| free_idx | output | CL x IDX_W | Per commit lane: index of the returned register |

## Verification
The bench builds the block with 16 registers, two rename lanes, three commit lanes, 2-bit counts and 8 initially mapped registers. With a saturation limit of three, the cap is reached after two cycles of double allocation. With three commit lanes, one cycle can carry a duplicate release of one register and an independent release of another. Counts are never read directly: the bench proves each count by how many single releases it takes before the free pulse appears.

// File: rtl/preg_refcount_pkg.sv
package preg_refcount_pkg;

    // Which destination a commit lane gives back
    typedef enum logic {
        REL_COMMIT = 1'b0,   // retirement: previous destination
        REL_WALK   = 1'b1    // recovery walk: new destination
    } rel_mode_e;

    // Clamp a signed running value into [0, hi]
    function automatic int clip_count(input int v, input int hi);
        if (v < 0)  return 0;
        if (v > hi) return hi;
        return v;
    endfunction

    // Width needed to hold values 0..n
    function automatic int count_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/refcnt_rel_sel.sv
module refcnt_rel_sel
    import preg_refcount_pkg::*;
#(
    parameter int CL    = 4,
    parameter int IDX_W = 6
) (
    input  logic                      walk_mode,
    input  logic [CL-1:0][IDX_W-1:0]  rel_new_idx,
    input  logic [CL-1:0][IDX_W-1:0]  rel_old_idx,
    output logic [CL-1:0][IDX_W-1:0]  rel_idx
);

    rel_mode_e mode;
    assign mode = rel_mode_e'(walk_mode);

    for (genvar l = 0; l < CL; l++) begin : g_lane
        always_comb begin
            if (mode == REL_WALK) rel_idx[l] = rel_new_idx[l];
            else                  rel_idx[l] = rel_old_idx[l];
        end
    end

endmodule

// File: rtl/refcnt_delta.sv
module refcnt_delta #(
    parameter int NUM_PREGS = 64,
    parameter int AL        = 4,
    parameter int CL        = 4,
    parameter int IDX_W     = 6,
    parameter int INC_W     = 3,
    parameter int DEC_W     = 3
) (
    input  logic [AL-1:0]             alloc_vld,
    input  logic [AL-1:0][IDX_W-1:0]  alloc_idx,
    input  logic [CL-1:0]             rel_vld,
    input  logic [CL-1:0][IDX_W-1:0]  rel_idx,
    output logic [NUM_PREGS-1:0][INC_W-1:0] inc_cnt,
    output logic [NUM_PREGS-1:0][DEC_W-1:0] dec_cnt
);

    for (genvar r = 0; r < NUM_PREGS; r++) begin : g_reg
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(r);

        always_comb begin
            inc_cnt[r] = '0;
            for (int l = 0; l < AL; l++) begin
                if (alloc_vld[l] && (alloc_idx[l] == MY_IDX))
                    inc_cnt[r] = inc_cnt[r] + INC_W'(1);
            end
        end

        always_comb begin
            dec_cnt[r] = '0;
            for (int l = 0; l < CL; l++) begin
                if (rel_vld[l] && (rel_idx[l] == MY_IDX))
                    dec_cnt[r] = dec_cnt[r] + DEC_W'(1);
            end
        end
    end

endmodule

// File: rtl/refcnt_bank.sv
module refcnt_bank
    import preg_refcount_pkg::*;
#(
    parameter int NUM_PREGS   = 64,
    parameter int CNT_W       = 3,
    parameter int INIT_MAPPED = 32,
    parameter int INC_W       = 3,
    parameter int DEC_W       = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_PREGS-1:0][INC_W-1:0]  inc_cnt,
    input  logic [NUM_PREGS-1:0][DEC_W-1:0]  dec_cnt,
    output logic [NUM_PREGS-1:0][CNT_W-1:0]  cnt_next
);

    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic [NUM_PREGS-1:0][CNT_W-1:0] cnt_q;

    for (genvar r = 0; r < NUM_PREGS; r++) begin : g_cnt
        localparam logic [CNT_W-1:0] RST_VAL =
            (r < INIT_MAPPED) ? CNT_W'(1) : CNT_W'(0);

        int sum;

        always_comb begin
            sum = int'(cnt_q[r]) + int'(inc_cnt[r]) - int'(dec_cnt[r]);
            cnt_next[r] = CNT_W'(clip_count(sum, CNT_MAX));
        end

        always_ff @(posedge clk) begin
            if (rst) cnt_q[r] <= RST_VAL;
            else     cnt_q[r] <= cnt_next[r];
        end
    end

endmodule

// File: rtl/refcnt_free_gen.sv
module refcnt_free_gen #(
    parameter int NUM_PREGS = 64,
    parameter int CL        = 4,
    parameter int IDX_W     = 6,
    parameter int CNT_W     = 3
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [CL-1:0]                    rel_vld,
    input  logic [CL-1:0][IDX_W-1:0]         rel_idx,
    input  logic [NUM_PREGS-1:0][CNT_W-1:0]  cnt_next,
    output logic [CL-1:0]                    free_vld,
    output logic [CL-1:0][IDX_W-1:0]         free_idx
);

    logic [CL-1:0] dup;
    logic [CL-1:0] hit;

    for (genvar l = 0; l < CL; l++) begin : g_lane
        // a lower lane already claims this register this cycle
        always_comb begin
            dup[l] = 1'b0;
            for (int k = 0; k < l; k++) begin
                if (rel_vld[k] && (rel_idx[k] == rel_idx[l]))
                    dup[l] = 1'b1;
            end
        end

        assign hit[l] = rel_vld[l] && !dup[l] &&
                        (cnt_next[rel_idx[l]] == '0);

        always_ff @(posedge clk) begin
            if (rst) begin
                free_vld[l] <= 1'b0;
                free_idx[l] <= '0;
            end else begin
                free_vld[l] <= hit[l];
                free_idx[l] <= hit[l] ? rel_idx[l] : '0;
            end
        end
    end

endmodule

// File: rtl/preg_refcount.sv
module preg_refcount
    import preg_refcount_pkg::*;
#(
    parameter int NUM_PREGS   = 64,
    parameter int AL          = 4,
    parameter int CL          = 4,
    parameter int CNT_W       = 3,
    parameter int INIT_MAPPED = 32,
    localparam int IDX_W      = $clog2(NUM_PREGS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [AL-1:0]             alloc_vld,
    input  logic [AL-1:0][IDX_W-1:0]  alloc_idx,
    input  logic                      walk_mode,
    input  logic [CL-1:0]             rel_vld,
    input  logic [CL-1:0][IDX_W-1:0]  rel_new_idx,
    input  logic [CL-1:0][IDX_W-1:0]  rel_old_idx,
    output logic [CL-1:0]             free_vld,
    output logic [CL-1:0][IDX_W-1:0]  free_idx
);

    localparam int INC_W = count_width(AL);
    localparam int DEC_W = count_width(CL);

    logic [CL-1:0][IDX_W-1:0]         rel_idx;
    logic [NUM_PREGS-1:0][INC_W-1:0]  inc_cnt;
    logic [NUM_PREGS-1:0][DEC_W-1:0]  dec_cnt;
    logic [NUM_PREGS-1:0][CNT_W-1:0]  cnt_next;

    refcnt_rel_sel #(.CL(CL), .IDX_W(IDX_W)) u_sel (
        .walk_mode   (walk_mode),
        .rel_new_idx (rel_new_idx),
        .rel_old_idx (rel_old_idx),
        .rel_idx     (rel_idx)
    );

    refcnt_delta #(
        .NUM_PREGS(NUM_PREGS), .AL(AL), .CL(CL),
        .IDX_W(IDX_W), .INC_W(INC_W), .DEC_W(DEC_W)
    ) u_delta (
        .alloc_vld (alloc_vld),
        .alloc_idx (alloc_idx),
        .rel_vld   (rel_vld),
        .rel_idx   (rel_idx),
        .inc_cnt   (inc_cnt),
        .dec_cnt   (dec_cnt)
    );

    refcnt_bank #(
        .NUM_PREGS(NUM_PREGS), .CNT_W(CNT_W), .INIT_MAPPED(INIT_MAPPED),
        .INC_W(INC_W), .DEC_W(DEC_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .inc_cnt  (inc_cnt),
        .dec_cnt  (dec_cnt),
        .cnt_next (cnt_next)
    );

    refcnt_free_gen #(
        .NUM_PREGS(NUM_PREGS), .CL(CL), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_free (
        .clk      (clk),
        .rst      (rst),
        .rel_vld  (rel_vld),
        .rel_idx  (rel_idx),
        .cnt_next (cnt_next),
        .free_vld (free_vld),
        .free_idx (free_idx)
    );

endmodule

// File: rtl/preg_refcount_chk.sv
module preg_refcount_chk #(
    parameter int CL    = 4,
    parameter int IDX_W = 6
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      walk_mode,
    input logic [CL-1:0]             rel_vld,
    input logic [CL-1:0][IDX_W-1:0]  rel_new_idx,
    input logic [CL-1:0][IDX_W-1:0]  rel_old_idx,
    input logic [CL-1:0]             free_vld,
    input logic [CL-1:0][IDX_W-1:0]  free_idx
);

    // R1: first cycle out of reset carries no free
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (free_vld == '0));

    for (genvar l = 0; l < CL; l++) begin : g_lane
        // R3: a free pulse always follows a release on the same lane
        a_r3_free_follows_release: assert property (@(posedge clk) disable iff (rst)
            free_vld[l] |-> $past(rel_vld[l]));

        // R2: freed index is the one chosen by the previous cycle's mode
        a_r2_free_index_by_mode: assert property (@(posedge clk) disable iff (rst)
            free_vld[l] |-> (free_idx[l] ==
                ($past(walk_mode) ? $past(rel_new_idx[l]) : $past(rel_old_idx[l]))));

        // R6: no two lanes free the same register in one cycle
        for (genvar m = l + 1; m < CL; m++) begin : g_pair
            a_r6_single_free: assert property (@(posedge clk) disable iff (rst)
                (free_vld[l] && free_vld[m]) |-> (free_idx[l] != free_idx[m]));
        end
    end

endmodule

bind preg_refcount preg_refcount_chk #(.CL(CL), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .walk_mode   (walk_mode),
    .rel_vld     (rel_vld),
    .rel_new_idx (rel_new_idx),
    .rel_old_idx (rel_old_idx),
    .free_vld    (free_vld),
    .free_idx    (free_idx)
);

// File: tb/preg_refcount_test.sv
module preg_refcount_test;

    localparam int NP    = 16;
    localparam int AL    = 2;
    localparam int CL    = 3;
    localparam int CW    = 2;
    localparam int INITM = 8;
    localparam int IW    = $clog2(NP);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [AL-1:0]       alloc_vld;
    logic [AL-1:0][IW-1:0] alloc_idx;
    logic                walk_mode;
    logic [CL-1:0]       rel_vld;
    logic [CL-1:0][IW-1:0] rel_new_idx;
    logic [CL-1:0][IW-1:0] rel_old_idx;
    logic [CL-1:0]       free_vld;
    logic [CL-1:0][IW-1:0] free_idx;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    preg_refcount #(
        .NUM_PREGS(NP), .AL(AL), .CL(CL), .CNT_W(CW), .INIT_MAPPED(INITM)
    ) uut (
        .clk(clk), .rst(rst),
        .alloc_vld(alloc_vld), .alloc_idx(alloc_idx),
        .walk_mode(walk_mode),
        .rel_vld(rel_vld), .rel_new_idx(rel_new_idx), .rel_old_idx(rel_old_idx),
        .free_vld(free_vld), .free_idx(free_idx)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clr();
        alloc_vld = '0; alloc_idx = '0; walk_mode = 1'b0;
        rel_vld = '0; rel_new_idx = '0; rel_old_idx = '0;
    endtask

    task automatic alloc(input int lane, input int idx);
        alloc_vld[lane] = 1'b1;
        alloc_idx[lane] = IW'(idx);
    endtask

    // commit-mode release of the previous destination
    task automatic rel(input int lane, input int idx);
        rel_vld[lane]     = 1'b1;
        rel_old_idx[lane] = IW'(idx);
        rel_new_idx[lane] = IW'((idx + 1) % NP);
    endtask

    // apply staged inputs for one edge, then clear them
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic step();
        tick();
        clr();
    endtask

    task automatic t_reset();
        chk("R1 free low after reset", int'(free_vld), 0);
        rel(0, 3);
        #2 chk("R3 no free before the edge", int'(free_vld), 0);
        step();
        chk("R1 mapped reg freed after one release", int'(free_vld), 1);
        chk("R1 freed index", int'(free_idx[0]), 3);
        tick();
        chk("R3 pulse lasts one cycle", int'(free_vld), 0);
        alloc(1, 10); step();
        chk("R1 unmapped reg: alloc alone frees nothing", int'(free_vld), 0);
        rel(2, 10); step();
        chk("R1 unmapped reg starts at zero", int'(free_vld), 4);
        chk("R3 free on releasing lane", int'(free_idx[2]), 10);
    endtask

    task automatic t_walk();
        walk_mode = 1'b1;
        rel_vld[1] = 1'b1; rel_new_idx[1] = IW'(5); rel_old_idx[1] = IW'(6);
        step();
        chk("R2 walk frees new index", int'(free_vld), 2);
        chk("R2 walk index", int'(free_idx[1]), 5);
        walk_mode = 1'b0;
        rel_vld[2] = 1'b1; rel_new_idx[2] = IW'(7); rel_old_idx[2] = IW'(4);
        step();
        chk("R2 commit frees old index", int'(free_vld), 4);
        chk("R2 commit index", int'(free_idx[2]), 4);
        rel(0, 6); step();
        chk("R2 walk left old index untouched", int'(free_vld), 1);
        rel(0, 7); step();
        chk("R2 commit left new index untouched", int'(free_vld), 1);
    endtask

    task automatic t_move();
        alloc(1, 0); step();
        rel(0, 0); step();
        chk("R4 shared reg not freed", int'(free_vld), 0);
        rel(1, 0); step();
        chk("R4 last reference frees", int'(free_vld), 2);
        chk("R4 index", int'(free_idx[1]), 0);
    endtask

    task automatic t_merge();
        alloc(0, 1); rel(0, 1); step();
        chk("R5 alloc+release same cycle: no free", int'(free_vld), 0);
        rel(0, 1); step();
        chk("R5 count unchanged by merged cycle", int'(free_vld), 1);
    endtask

    task automatic t_multi();
        alloc(0, 11); alloc(1, 11); step();
        rel(0, 11); rel(1, 2); rel(2, 11); step();
        chk("R6 only lowest duplicate lane frees", int'(free_vld), 3);
        chk("R6 lane0 index", int'(free_idx[0]), 11);
        chk("R6 independent lane index", int'(free_idx[1]), 2);
    endtask

    task automatic t_sat();
        alloc(0, 12); alloc(1, 12); step();
        alloc(0, 12); alloc(1, 12); step();
        rel(0, 12); rel(1, 12); step();
        chk("R7 saturated count survives two releases", int'(free_vld), 0);
        rel(2, 12); step();
        chk("R7 third release frees at cap of three", int'(free_vld), 4);
        chk("R7 index", int'(free_idx[2]), 12);
    endtask

    task automatic t_ignore();
        alloc(0, 15); step();
        alloc_idx[0] = IW'(15); alloc_idx[1] = IW'(15);
        rel_old_idx = '{IW'(15), IW'(15), IW'(15)};
        rel_new_idx = '{IW'(15), IW'(15), IW'(15)};
        step();
        chk("R8 invalid lanes produce no free", int'(free_vld), 0);
        rel(1, 15); step();
        chk("R8 invalid lanes left count at one", int'(free_vld), 2);
        chk("R8 index", int'(free_idx[1]), 15);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        clr();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        tick();
        t_reset();
        t_walk();
        t_move();
        t_merge();
        t_multi();
        t_sat();
        t_ignore();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule